// File: doc/BRIEF.md
# Serial Matrix Panel Video Timing Driver

This block drives a monochrome matrix panel over a four-wire serial video link: a pixel clock, one data bit per pixel, a horizontal sync and a vertical sync. The pixel clock comes from dividing the system clock. Two counters, one for the pixel slot and one for the line, track the raster. For each visible slot the block pulls one pixel bit from an upstream source through a ready/valid handshake. All outputs change together with the rising pixel-clock edge, so each one holds steady across the following falling edge, where the panel latches it.

The visible window is `VIS_COLS` by `VIS_ROWS` (276 by 128 by default). A line is padded to a runtime length that is a multiple of four. Padding slots come first in the line and are sent as zeros. Horizontal sync is high during the last slot of each line, so the visible pixels are the last ones before sync falls. Vertical sync is high through the whole first line and for `VS_HOLD` slots into the second line, which gives setup and hold around the end of line one. Software-free runtime configuration sets the half-period of the divider, the padded line length and the number of lines. A write that breaks a rule is dropped. A legal write is held in a pending register and takes effect at the next frame boundary.

Top module: `elpanel_drv`

## Requirements
- R1: While reset is high, and in the cycle after it, `pclk`, `pdata`, `hsync`, `vsync`, `px_ready` and `underflow` are all low.
- R2: After the first toggle, each high phase and each low phase of `pclk` lasts exactly the active half-period count of system clocks. The clock runs without pause, blanking included.
- R3: `pdata`, `hsync` and `vsync` change only on the system clock edge where `pclk` rises.
- R4: `hsync` is high for exactly one slot per line, the last one (slot index `len-1`). A line is `len` pixel clocks long.
- R5: Slots 0 to `len-VIS_COLS-1` of each line are padding. They send 0, and `px_ready` stays low for them.
- R6: `px_ready` pulses for exactly one system cycle per visible slot, with `pclk` low, on the edge where `pclk` rises. The bit taken then appears on `pdata` from that edge. Pixels go out left to right, then top to bottom.
- R7: `vsync` is high for all of line 0 and for slots 0 to `VS_HOLD-1` of line 1, and low otherwise. A frame is `rows` lines long.
- R8: A configuration write is dropped, and the previous setting kept, in any of these cases: the length is below `VIS_COLS`; the length is not a multiple of 4; the line count is below `VIS_ROWS`; the half-period is outside `MIN_HALF..MAX_HALF`. A legal write takes effect at the first frame start after it.
- R9: If `px_valid` is low when `px_ready` pulses, that slot sends 0 and `underflow` is set. `underflow` then stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_half | input | 8 | Pixel-clock half-period, in system clocks |
| cfg_len | input | 10 | Padded line length, in pixel clocks |
| cfg_rows | input | 10 | Lines per frame |
| px_valid | input | 1 | Upstream pixel bit available |
| px_bit | input | 1 | Upstream pixel bit, 1 means lit |
| px_ready | output | 1 | Pixel bit taken this cycle |
| pclk | output | 1 | Pixel clock to the panel |
| pdata | output | 1 | Serial pixel data |
| hsync | output | 1 | Last-slot-of-line marker |
| vsync | output | 1 | Frame marker |
| underflow | output | 1 | Sticky starvation flag |

## Verification
The last slot of a frame does three things on one edge: it raises `hsync`, it takes the final visible pixel, and it reloads the configuration from the pending register. So a starved pixel and a change of line length can land on the same edge. The bench provokes this with a legal write that changes length, line count and half-period, followed by a stretch in which `px_valid` stays low through the frame boundary. It then checks that the starved slot sends 0, that `underflow` rises, that `hsync` fell on the old length, and that the following lines and clock phases follow the new values.

// File: rtl/elp_pkg.sv
package elp_pkg;

    localparam int HALF_W = 8;
    localparam int LEN_W  = 10;
    localparam int ROW_W  = 10;

    typedef struct packed {
        logic [HALF_W-1:0] half;
        logic [LEN_W-1:0]  len;
        logic [ROW_W-1:0]  rows;
    } elp_cfg_t;

    typedef struct packed {
        logic pix;
        logic hs;
        logic vs;
    } elp_out_t;

    // Legality of a requested raster setting
    function automatic logic cfg_ok(elp_cfg_t c, int vis_cols, int vis_rows,
                                    int min_half, int max_half);
        return (int'(c.len) >= vis_cols) && (c.len[1:0] == 2'b00) &&
               (int'(c.rows) >= vis_rows) &&
               (int'(c.half) >= min_half) && (int'(c.half) <= max_half);
    endfunction

endpackage

// File: rtl/elp_clkdiv.sv
module elp_clkdiv
    import elp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [HALF_W-1:0] half,
    output logic              pclk,
    output logic              rise
);
    logic [HALF_W-1:0] cnt;
    logic              tick;

    assign tick = (cnt >= (half - 1'b1));
    assign rise = tick & ~pclk & ~rst;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= '0;
            pclk <= 1'b0;
        end else if (tick) begin
            cnt  <= '0;
            pclk <= ~pclk;
        end else begin
            cnt  <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/elp_cfg_reg.sv
module elp_cfg_reg
    import elp_pkg::*;
#(
    parameter int VIS_COLS = 276,
    parameter int VIS_ROWS = 128,
    parameter int MIN_HALF = 30,
    parameter int MAX_HALF = 78,
    parameter int DEF_HALF = 32,
    parameter int DEF_LEN  = 280,
    parameter int DEF_ROWS = 128
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     wr,
    input  elp_cfg_t wr_cfg,
    input  logic     load,
    output elp_cfg_t act
);
    localparam elp_cfg_t DEF_CFG = '{half: HALF_W'(DEF_HALF),
                                     len:  LEN_W'(DEF_LEN),
                                     rows: ROW_W'(DEF_ROWS)};

    elp_cfg_t pend;
    logic     accept;

    assign accept = wr && cfg_ok(wr_cfg, VIS_COLS, VIS_ROWS, MIN_HALF, MAX_HALF);

    always_ff @(posedge clk) begin
        if (rst) begin
            pend <= DEF_CFG;
            act  <= DEF_CFG;
        end else begin
            if (accept) pend <= wr_cfg;
            if (load)   act  <= pend;
        end
    end
endmodule

// File: rtl/elp_raster.sv
module elp_raster
    import elp_pkg::*;
#(
    parameter int VIS_COLS = 276,
    parameter int VS_HOLD  = 8
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     step,
    input  elp_cfg_t act,
    output logic     visible,
    output logic     frame_end,
    output elp_out_t marks
);
    logic [LEN_W-1:0] col;
    logic [ROW_W-1:0] row;
    logic             line_end;
    logic             last_row;

    assign line_end  = (col == (act.len - 1'b1));
    assign last_row  = (row == (act.rows - 1'b1));
    assign frame_end = line_end & last_row;
    assign visible   = (col >= (act.len - LEN_W'(VIS_COLS)));

    always_comb begin
        marks.pix = 1'b0;
        marks.hs  = line_end;
        marks.vs  = (row == '0) || ((row == ROW_W'(1)) && (col < LEN_W'(VS_HOLD)));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            col <= '0;
            row <= '0;
        end else if (step) begin
            if (line_end) begin
                col <= '0;
                row <= last_row ? '0 : row + 1'b1;
            end else begin
                col <= col + 1'b1;
            end
        end
    end
endmodule

// File: rtl/elpanel_drv.sv
module elpanel_drv
    import elp_pkg::*;
#(
    parameter int VIS_COLS = 276,
    parameter int VIS_ROWS = 128,
    parameter int MIN_HALF = 30,
    parameter int MAX_HALF = 78,
    parameter int DEF_HALF = 32,
    parameter int DEF_LEN  = 280,
    parameter int DEF_ROWS = 128,
    parameter int VS_HOLD  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [HALF_W-1:0] cfg_half,
    input  logic [LEN_W-1:0]  cfg_len,
    input  logic [ROW_W-1:0]  cfg_rows,
    input  logic              px_valid,
    input  logic              px_bit,
    output logic              px_ready,
    output logic              pclk,
    output logic              pdata,
    output logic              hsync,
    output logic              vsync,
    output logic              underflow
);
    elp_cfg_t act;
    elp_cfg_t wr_cfg;
    elp_out_t marks;
    elp_out_t out_q;
    logic     rise;
    logic     visible;
    logic     frame_end;

    assign wr_cfg = '{half: cfg_half, len: cfg_len, rows: cfg_rows};

    elp_cfg_reg #(
        .VIS_COLS(VIS_COLS), .VIS_ROWS(VIS_ROWS),
        .MIN_HALF(MIN_HALF), .MAX_HALF(MAX_HALF),
        .DEF_HALF(DEF_HALF), .DEF_LEN(DEF_LEN), .DEF_ROWS(DEF_ROWS)
    ) u_cfg (
        .clk(clk), .rst(rst), .wr(cfg_we), .wr_cfg(wr_cfg),
        .load(rise & frame_end), .act(act)
    );

    elp_clkdiv u_div (
        .clk(clk), .rst(rst), .half(act.half), .pclk(pclk), .rise(rise)
    );

    elp_raster #(.VIS_COLS(VIS_COLS), .VS_HOLD(VS_HOLD)) u_ras (
        .clk(clk), .rst(rst), .step(rise), .act(act),
        .visible(visible), .frame_end(frame_end), .marks(marks)
    );

    assign px_ready = rise & visible;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q     <= '0;
            underflow <= 1'b0;
        end else if (rise) begin
            out_q.pix <= visible & px_valid & px_bit;
            out_q.hs  <= marks.hs;
            out_q.vs  <= marks.vs;
            if (visible && !px_valid) underflow <= 1'b1;
        end
    end

    assign pdata = out_q.pix;
    assign hsync = out_q.hs;
    assign vsync = out_q.vs;
endmodule

// File: rtl/elp_drv_chk.sv
module elp_drv_chk (
    input logic clk,
    input logic rst,
    input logic px_valid,
    input logic px_bit,
    input logic px_ready,
    input logic pclk,
    input logic pdata,
    input logic hsync,
    input logic vsync,
    input logic underflow
);
    // R1
    reset_idle_chk: assert property (@(posedge clk)
        rst |=> (!pclk && !pdata && !hsync && !vsync && !underflow));

    // R3
    hold_between_rises_chk: assert property (@(posedge clk) disable iff (rst)
        !$rose(pclk) |-> ($stable(pdata) && $stable(hsync) && $stable(vsync)));

    // R6
    ready_low_phase_chk: assert property (@(posedge clk) disable iff (rst)
        px_ready |-> !pclk);

    // R6
    ready_then_rise_chk: assert property (@(posedge clk) disable iff (rst)
        px_ready |=> $rose(pclk));

    // R6
    taken_bit_shown_chk: assert property (@(posedge clk) disable iff (rst)
        (px_ready && px_valid) |=> (pdata == $past(px_bit)));

    // R9
    starved_slot_chk: assert property (@(posedge clk) disable iff (rst)
        (px_ready && !px_valid) |=> (underflow && !pdata));

    // R9
    flag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        underflow |=> underflow);
endmodule

bind elpanel_drv elp_drv_chk chk_i (
    .clk(clk), .rst(rst), .px_valid(px_valid), .px_bit(px_bit),
    .px_ready(px_ready), .pclk(pclk), .pdata(pdata), .hsync(hsync),
    .vsync(vsync), .underflow(underflow)
);

// File: tb/elpanel_drv_tb_top.sv
module elpanel_drv_tb_top;
    import elp_pkg::*;

    localparam int VC = 12, VR = 4, MNH = 1, MXH = 8;
    localparam int DH = 2, DL = 16, DR = 4, VH = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    logic              cfg_we = 1'b0;
    logic [HALF_W-1:0] cfg_half = '0;
    logic [LEN_W-1:0]  cfg_len = '0;
    logic [ROW_W-1:0]  cfg_rows = '0;
    logic              px_valid = 1'b0, px_bit = 1'b0;
    logic              px_ready, pclk, pdata, hsync, vsync, underflow;

    elpanel_drv #(
        .VIS_COLS(VC), .VIS_ROWS(VR), .MIN_HALF(MNH), .MAX_HALF(MXH),
        .DEF_HALF(DH), .DEF_LEN(DL), .DEF_ROWS(DR), .VS_HOLD(VH)
    ) dut_i (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_half(cfg_half),
        .cfg_len(cfg_len), .cfg_rows(cfg_rows), .px_valid(px_valid),
        .px_bit(px_bit), .px_ready(px_ready), .pclk(pclk), .pdata(pdata),
        .hsync(hsync), .vsync(vsync), .underflow(underflow)
    );

    int n_run = 0, n_fail = 0;
    int m_half = DH, m_len = DL, m_rows = DR;
    int p_half = DH, p_len = DL, p_rows = DR;
    int col = 0, row = 0;
    int phase_cnt = 0, phase_half = DH;
    bit first_tog = 1'b1;
    logic prev_pclk = 1'b0, prev_d = 1'b0, prev_h = 1'b0, prev_v = 1'b0;
    logic saw_ready = 1'b0, exp_bit = 1'b0, m_uf = 1'b0;
    bit want_wr = 1'b0, wr_now = 1'b0;
    int w_half = 0, w_len = 0, w_rows = 0;
    int wd = 0;

    function automatic bit cfg_valid(int h, int l, int r);
        return (l >= VC) && (l % 4 == 0) && (r >= VR) && (h >= MNH) && (h <= MXH);
    endfunction

    function automatic bit exp_vs(int r, int c);
        return (r == 0) || (r == 1 && c < VH);
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step(int vpct);
        bit vis;
        bit fe;
        @(negedge clk);
        if (pclk != prev_pclk) begin
            if (!first_tog)
                check(phase_cnt == phase_half, "R2 pclk phase length", phase_cnt, phase_half);
            first_tog = 1'b0;
            if (pclk) begin
                vis = (col >= m_len - VC);
                check(hsync == (col == m_len - 1), "R4 hsync on last slot", hsync, col == m_len - 1);
                check(vsync == exp_vs(row, col), "R7 vsync window", vsync, exp_vs(row, col));
                if (vis) begin
                    check(saw_ready == 1'b1, "R6 ready for visible slot", saw_ready, 1);
                    check(pdata == exp_bit, "R6 pixel bit", pdata, exp_bit);
                end else begin
                    check(saw_ready == 1'b0, "R5 no ready in padding", saw_ready, 0);
                    check(pdata == 1'b0, "R5 padding zero", pdata, 0);
                end
                check(underflow == m_uf, "R9 underflow flag", underflow, m_uf);
                fe = (col == m_len - 1) && (row == m_rows - 1);
                if (col == m_len - 1) begin
                    col = 0;
                    row = (row == m_rows - 1) ? 0 : row + 1;
                end else begin
                    col++;
                end
                if (fe) begin
                    m_half = p_half; m_len = p_len; m_rows = p_rows;
                end
                saw_ready = 1'b0;
            end
            phase_half = m_half;
            phase_cnt = 1;
        end else begin
            phase_cnt++;
            check(pdata == prev_d && hsync == prev_h && vsync == prev_v,
                  "R3 outputs hold between rises", {pdata, hsync, vsync}, {prev_d, prev_h, prev_v});
        end
        prev_pclk = pclk; prev_d = pdata; prev_h = hsync; prev_v = vsync;
        if (wr_now) begin
            if (cfg_valid(w_half, w_len, w_rows)) begin
                p_half = w_half; p_len = w_len; p_rows = w_rows;
            end
            wr_now = 1'b0;
            cfg_we = 1'b0;
        end
        px_valid = ($urandom_range(99) < vpct);
        px_bit = $urandom_range(1);
        if (px_ready) begin
            saw_ready = 1'b1;
            exp_bit = px_valid & px_bit;
            if (!px_valid) m_uf = 1'b1;
        end
        if (want_wr) begin
            cfg_we = 1'b1;
            cfg_half = HALF_W'(w_half);
            cfg_len = LEN_W'(w_len);
            cfg_rows = ROW_W'(w_rows);
            want_wr = 1'b0;
            wr_now = 1'b1;
        end
    endtask

    task automatic run(int n, int vpct);
        for (int i = 0; i < n; i++) step(vpct);
    endtask

    task automatic cfg_write(int h, int l, int r);
        w_half = h; w_len = l; w_rows = r;
        want_wr = 1'b1;
        step(100);
        step(100);
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    always @(posedge clk) begin
        wd++;
        if (wd > 150000) begin
            n_fail++;
            n_run++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", wd, 0);
            finish_run();
        end
    end

    initial begin
        void'($urandom(1234));
        repeat (3) @(negedge clk);
        // R1: reset values visible at the ports
        check({pclk, pdata, hsync, vsync, px_ready, underflow} == 6'b0,
              "R1 reset state", {pclk, pdata, hsync, vsync, px_ready, underflow}, 0);
        rst = 1'b0;
        // full supply: no underflow over two frames
        run(600, 100);
        // random supply with starvation
        run(800, 85);
        // R8: rejected writes, each with other fields that would be visible
        cfg_write(3, 14, 5);   // length not a multiple of 4
        cfg_write(3, 8, 5);    // length below visible width
        cfg_write(3, 20, 3);   // too few lines
        cfg_write(9, 20, 5);   // half-period too large
        cfg_write(0, 20, 5);   // half-period too small
        run(700, 90);
        // R8: legal change, then starve across the frame boundary
        cfg_write(1, 20, 5);
        run(250, 95);
        run(120, 0);
        run(500, 80);
        // R8/R5: length equal to the visible width, no padding
        cfg_write(3, 12, 6);
        run(1500, 90);
        finish_run();
    end
endmodule